// File: doc/BRIEF.md
# Mixed-Radix Phase Accumulator Clock Generator

This block derives a fractional-rate clock enable from one fast system clock. It uses only synchronous rising-edge logic. It keeps a phase word made of two fields. The upper field counts modulo an arbitrary integer `MOD_P`. The lower field is an ordinary binary fraction `FRAC_W` bits wide, and its carry feeds the upper field. On each enabled cycle the phase advances by a programmable increment. When the upper field passes its modulus, a one-cycle tick is raised and the phase folds back into range.

The full modulus is T = `MOD_P`·2^`FRAC_W`. With increment K, the tick rate is K·Fc/T. Every multiple of Fc/T is therefore produced exactly, with no long-term drift. When T/K is not an integer, the spacing between ticks alternates between floor(T/K) and ceil(T/K) cycles in a repeating pattern. Each edge lands on a system clock edge, so the timing error is a sawtooth bounded by one clock.

A square output toggles on every tick, which gives half the tick rate. The increment is written through a load strobe and held internally, so it changes only between accumulation steps.

Top module: `mrclk_gen`

## Requirements
- R1: On every enabled, non-reset cycle, the phase value P = `phase_hi_o`·2^`FRAC_W` + `phase_lo_o` becomes (P + K) mod T, where K = inc_hi·2^`FRAC_W` + inc_lo is the held increment and T = `MOD_P`·2^`FRAC_W`.
- R2: `phase_hi_o` is always less than `MOD_P`.
- R3: `tick_o` is high for exactly the one cycle that follows an edge where P + K reached or exceeded T. It is registered on the same edge as the phase update.
- R4: The increment is captured from `inc_hi_i`/`inc_lo_i` on an edge where `load_i` is high, and is first used on the following edge. An `inc_hi_i` value at or above `MOD_P` is stored as `MOD_P`-1, and the lower part is kept as given.
- R5: Synchronous reset clears the phase, `tick_o`, `sq_o` and the held increment to zero.
- R6: `sq_o` inverts on the same edge that raises `tick_o`, and holds its value otherwise.
- R7: While `en_i` is low, the phase holds and `tick_o` stays low. A load during this time is still captured.
- R8: A held increment of zero produces no ticks, and the phase does not move.
- R9: For an increment K, each tick-to-tick interval is floor(T/K) or ceil(T/K) cycles. Any window of T/gcd(T,K) enabled cycles holds exactly K/gcd(T,K) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Accumulation enable |
| load_i | input | 1 | Increment load strobe |
| inc_hi_i | input | HI_W | Upper (modulo) part of increment |
| inc_lo_i | input | FRAC_W | Lower (binary) part of increment |
| tick_o | output | 1 | One-cycle pulse per phase wrap |
| sq_o | output | 1 | Square output, toggles per tick |
| phase_hi_o | output | HI_W | Upper phase field, 0..MOD_P-1 |
| phase_lo_o | output | FRAC_W | Lower phase field |

## Verification
The phase, tick and square outputs all change on the first rising edge after the inputs that cause them. A load, however, changes only the held increment at that edge, so its value appears in the phase one edge later. The bench drives inputs on the falling edge and samples all outputs one time unit after the next rising edge. It advances an integer model of the phase in the same order as the design: it first accumulates with the previously held increment, then applies any load. Interval and window counts are taken from the observed tick at those sample points. They are compared with floor/ceil of T/K and with K/gcd(T,K).

// File: rtl/mrcg_pkg.sv
package mrcg_pkg;

   // Reduction variant selected for the upper phase field
   typedef enum logic {
      RED_NATIVE   = 1'b0,  // modulus is a power of two, carry-out wraps
      RED_SUBTRACT = 1'b1   // arbitrary modulus, compare and subtract once
   } red_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic red_kind_e pick_red(input int unsigned m);
      return is_pow2(m) ? RED_NATIVE : RED_SUBTRACT;
   endfunction

endpackage

// File: rtl/mrcg_inc_reg.sv
module mrcg_inc_reg #(
   parameter int unsigned MOD_P  = 10,
   parameter int unsigned HI_W   = 4,
   parameter int unsigned FRAC_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [HI_W-1:0]   hi_i,
   input  logic [FRAC_W-1:0] lo_i,
   output logic [HI_W-1:0]   hi_q_o,
   output logic [FRAC_W-1:0] lo_q_o
);
   localparam logic [HI_W:0]   MOD_W  = (HI_W+1)'(MOD_P);
   localparam logic [HI_W-1:0] HI_MAX = HI_W'(MOD_P - 1);

   logic            over;
   logic [HI_W-1:0] hi_lim;

   always_comb begin
      over   = ({1'b0, hi_i} >= MOD_W);
      hi_lim = over ? HI_MAX : hi_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hi_q_o <= '0;
         lo_q_o <= '0;
      end else if (load_i) begin
         hi_q_o <= hi_lim;
         lo_q_o <= lo_i;
      end
   end
endmodule

// File: rtl/mrcg_phase_acc.sv
module mrcg_phase_acc
   import mrcg_pkg::*;
#(
   parameter int unsigned MOD_P  = 10,
   parameter int unsigned HI_W   = 4,
   parameter int unsigned FRAC_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [HI_W-1:0]   inc_hi_i,
   input  logic [FRAC_W-1:0] inc_lo_i,
   output logic [HI_W-1:0]   ph_hi_o,
   output logic [FRAC_W-1:0] ph_lo_o,
   output logic              tick_o,
   output logic              wrap_o
);
   localparam red_kind_e     RED   = pick_red(MOD_P);
   localparam logic [HI_W:0] MOD_W = (HI_W+1)'(MOD_P);

   logic [FRAC_W:0]   lo_sum;
   logic              lo_cy;
   logic [HI_W:0]     hi_sum;
   logic [HI_W-1:0]   hi_next;
   logic              wrap_c;

   always_comb begin
      lo_sum = {1'b0, ph_lo_o} + {1'b0, inc_lo_i};
      lo_cy  = lo_sum[FRAC_W];
      hi_sum = {1'b0, ph_hi_o} + {1'b0, inc_hi_i} + {{HI_W{1'b0}}, lo_cy};
   end

   generate
      if (RED == RED_NATIVE) begin : g_native
         always_comb begin
            wrap_c  = hi_sum[HI_W];
            hi_next = hi_sum[HI_W-1:0];
         end
      end else begin : g_subtract
         logic [HI_W:0] hi_red;
         always_comb begin
            wrap_c  = (hi_sum >= MOD_W);
            hi_red  = hi_sum - MOD_W;
            hi_next = wrap_c ? hi_red[HI_W-1:0] : hi_sum[HI_W-1:0];
         end
      end
   endgenerate

   assign wrap_o = wrap_c & en_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ph_hi_o <= '0;
         ph_lo_o <= '0;
         tick_o  <= 1'b0;
      end else if (en_i) begin
         ph_hi_o <= hi_next;
         ph_lo_o <= lo_sum[FRAC_W-1:0];
         tick_o  <= wrap_c;
      end else begin
         tick_o  <= 1'b0;
      end
   end
endmodule

// File: rtl/mrcg_sq_out.sv
module mrcg_sq_out (
   input  logic clk_i,
   input  logic rst_i,
   input  logic wrap_i,
   output logic sq_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)       sq_o <= 1'b0;
      else if (wrap_i) sq_o <= ~sq_o;
   end
endmodule

// File: rtl/mrclk_gen.sv
module mrclk_gen #(
   parameter int unsigned MOD_P  = 10,
   parameter int unsigned FRAC_W = 4,
   localparam int unsigned HI_W  = (MOD_P < 2) ? 1 : $clog2(MOD_P)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic              load_i,
   input  logic [HI_W-1:0]   inc_hi_i,
   input  logic [FRAC_W-1:0] inc_lo_i,
   output logic              tick_o,
   output logic              sq_o,
   output logic [HI_W-1:0]   phase_hi_o,
   output logic [FRAC_W-1:0] phase_lo_o
);
   generate
      if (MOD_P < 2) begin : g_bad_mod
         $error("mrclk_gen: MOD_P must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("mrclk_gen: FRAC_W must be at least 1");
      end
   endgenerate

   logic [HI_W-1:0]   inc_hi_q;
   logic [FRAC_W-1:0] inc_lo_q;
   logic              wrap;

   mrcg_inc_reg #(.MOD_P(MOD_P), .HI_W(HI_W), .FRAC_W(FRAC_W)) inc_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (load_i),
      .hi_i   (inc_hi_i),
      .lo_i   (inc_lo_i),
      .hi_q_o (inc_hi_q),
      .lo_q_o (inc_lo_q)
   );

   mrcg_phase_acc #(.MOD_P(MOD_P), .HI_W(HI_W), .FRAC_W(FRAC_W)) acc_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .inc_hi_i (inc_hi_q),
      .inc_lo_i (inc_lo_q),
      .ph_hi_o  (phase_hi_o),
      .ph_lo_o  (phase_lo_o),
      .tick_o   (tick_o),
      .wrap_o   (wrap)
   );

   mrcg_sq_out sq_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .wrap_i (wrap),
      .sq_o   (sq_o)
   );
endmodule

// File: rtl/mrclk_gen_chk.sv
module mrclk_gen_chk #(
   parameter int unsigned MOD_P  = 10,
   parameter int unsigned FRAC_W = 4,
   parameter int unsigned HI_W   = 4
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic              tick_o,
   input logic              sq_o,
   input logic [HI_W-1:0]   phase_hi_o,
   input logic [FRAC_W-1:0] phase_lo_o
);
   logic [HI_W+FRAC_W-1:0] ph;
   assign ph = {phase_hi_o, phase_lo_o};

   AST_PHASE_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(!rst_i) && $past(en_i) && !tick_o) |-> (ph >= $past(ph))); // R1

   AST_HI_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      ({1'b0, phase_hi_o} < (HI_W+1)'(MOD_P))); // R2

   AST_TICK_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(!rst_i) && tick_o) |-> (ph < $past(ph))); // R3

   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> (ph == '0 && !tick_o && !sq_o)); // R5

   AST_SQ_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(!rst_i) |-> ((sq_o != $past(sq_o)) == tick_o)); // R6

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(!rst_i) && !$past(en_i)) |-> (!tick_o && ph == $past(ph))); // R7
endmodule

bind mrclk_gen mrclk_gen_chk #(.MOD_P(MOD_P), .FRAC_W(FRAC_W), .HI_W(HI_W)) chk_i (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .en_i       (en_i),
   .tick_o     (tick_o),
   .sq_o       (sq_o),
   .phase_hi_o (phase_hi_o),
   .phase_lo_o (phase_lo_o)
);

// File: tb/mrclk_gen_tb_top.sv
`timescale 1ns/1ps
module mrclk_gen_tb_top;
   localparam int MOD = 10;
   localparam int FW  = 4;
   localparam int HW  = 4;
   localparam int T   = MOD * (1 << FW);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b0;
   logic          ld = 1'b0;
   logic [HW-1:0] ihi = '0;
   logic [FW-1:0] ilo = '0;
   logic          tick, sq;
   logic [HW-1:0] phi;
   logic [FW-1:0] plo;

   int n_chk = 0, n_fail = 0;
   int ref_ph = 0, ref_inc = 0;
   bit exp_tick = 0, exp_sq = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mrclk_gen #(.MOD_P(MOD), .FRAC_W(FW)) dut_i (
      .clk_i(clk), .rst_i(rst), .en_i(en), .load_i(ld),
      .inc_hi_i(ihi), .inc_lo_i(ilo),
      .tick_o(tick), .sq_o(sq), .phase_hi_o(phi), .phase_lo_o(plo));

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int gcd(input int a, input int b);
      int x = a, y = b;
      while (y != 0) begin
         int t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int phase_now();
      return int'(phi) * (1 << FW) + int'(plo);
   endfunction

   // One clock: drive at negedge, sample 1 ns after posedge, compare with model
   task automatic step(input bit r, input bit e, input bit l,
                       input int hi, input int lo, input string req);
      @(negedge clk);
      rst = r; en = e; ld = l; ihi = HW'(hi); ilo = FW'(lo);
      @(posedge clk);
      #1;
      if (r) begin
         ref_ph = 0; ref_inc = 0; exp_tick = 0; exp_sq = 0;
      end else begin
         if (e) begin
            int s = ref_ph + ref_inc;
            exp_tick = (s >= T);
            if (exp_tick) begin
               s -= T;
               exp_sq = ~exp_sq;
            end
            ref_ph = s;
         end else begin
            exp_tick = 0;
         end
         if (l) ref_inc = ((hi >= MOD) ? MOD - 1 : hi) * (1 << FW) + lo;
      end
      chk(phase_now() == ref_ph, req, phase_now(), ref_ph);
      chk(tick == exp_tick, {req, "/R3 tick"}, int'(tick), int'(exp_tick));
      chk(sq == exp_sq, {req, "/R6 sq"}, int'(sq), int'(exp_sq));
   endtask

   task automatic load_k(input int k, input bit e, input string req);
      step(0, e, 1, k / (1 << FW), k % (1 << FW), req);
   endtask

   task automatic t_reset();
      step(1, 0, 0, 0, 0, "R5");
      step(1, 1, 1, 3, 3, "R5");
      chk(phase_now() == 0 && !tick && !sq, "R5 reset state", phase_now(), 0);
      load_k(100, 1, "R5");
      step(0, 1, 0, 0, 0, "R5");
      step(1, 1, 0, 0, 0, "R5");
      step(0, 1, 0, 0, 0, "R5");
      chk(phase_now() == 0, "R5 increment cleared", phase_now(), 0);
   endtask

   // Interval and window check for increment k
   task automatic t_pattern(input int k, input string req);
      int g, per, nt, last, lo_i, hi_i, first, cnt, cyc;
      g = gcd(T, k);
      per = T / g;
      lo_i = T / k;
      hi_i = (T + k - 1) / k;
      load_k(k, 1, req);
      first = -1; last = -1; cnt = 0; nt = 0; cyc = 0;
      for (int i = 0; i < 2 * per + hi_i + 2; i++) begin
         step(0, 1, 0, 0, 0, req);
         cyc++;
         if (first >= 0 && cyc - first <= per && tick) nt++;
         if (tick) begin
            if (last >= 0) begin
               chk((cyc - last == lo_i) || (cyc - last == hi_i), "R9 interval",
                   cyc - last, lo_i);
               cnt++;
            end
            if (first < 0) first = cyc;
            last = cyc;
         end
      end
      chk(cnt > 0, "R9 intervals seen", cnt, 1);
      chk(nt == k / g, "R9 window tick count", nt, k / g);
   endtask

   task automatic t_zero();
      int nt = 0;
      load_k(0, 1, "R8");
      for (int i = 0; i < 40; i++) begin
         step(0, 1, 0, 0, 0, "R8");
         if (tick) nt++;
      end
      chk(nt == 0, "R8 no ticks", nt, 0);
   endtask

   task automatic t_enable();
      int p0;
      load_k(40, 1, "R7");
      step(0, 1, 0, 0, 0, "R7");
      p0 = phase_now();
      for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, "R7");
      chk(phase_now() == p0, "R7 phase held", phase_now(), p0);
      load_k(7, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");
      step(0, 1, 0, 0, 0, "R7");
      chk(phase_now() == (p0 + 7) % T, "R7 load while idle", phase_now(), (p0 + 7) % T);
   endtask

   task automatic t_load_mid();
      int p0;
      load_k(26, 1, "R4");
      for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, "R4");
      p0 = phase_now();
      load_k(50, 1, "R4");
      chk(phase_now() == (p0 + 26) % T, "R4 old increment on load edge",
          phase_now(), (p0 + 26) % T);
      step(0, 1, 0, 0, 0, "R4");
      chk(phase_now() == (p0 + 76) % T, "R4 new increment next edge",
          phase_now(), (p0 + 76) % T);
      for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0, "R1");
   endtask

   task automatic t_clamp();
      int p0;
      step(0, 1, 1, 15, 3, "R4");
      p0 = phase_now();
      step(0, 1, 0, 0, 0, "R4");
      chk(phase_now() == (p0 + 9 * 16 + 3) % T, "R4 clamp upper part",
          phase_now(), (p0 + 147) % T);
      for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, "R2");
      chk(int'(phi) < MOD, "R2 upper field range", int'(phi), MOD - 1);
   endtask

   initial begin
      t_reset();
      t_pattern(26, "R1");
      t_pattern(16, "R1");
      t_pattern(159, "R1");
      t_zero();
      t_enable();
      t_load_mid();
      t_clamp();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule